// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a two-channel serial audio stream, made of a bit clock, a frame clock and a data line, and turns it into parallel left and right samples. All three serial lines pass through synchronizer flops into the system clock domain. The block then finds bit-clock rising edges and frame-clock transitions, and from these it works out where each sample sits within its half frame.

A 3-bit format select, which may change at run time, picks the framing. The choices are left-justified 24-bit, right-justified 24, 20 or 16-bit, and an I2S-style framing that uses a one-bit delay. Every sample is delivered as a 24-bit two's complement word, and shorter words are sign-extended. A single-cycle strobe marks each completed frame, with both channels presented together. The serial lines must be slow enough that each bit-clock phase spans at least three system clocks.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With `fmt_i` = 2, the first 24 data bits after a frame-clock transition form the sample, MSB first. Frame clock high carries the left channel and frame clock low carries the right.
- R3: With `fmt_i` = 3, frame clock low carries the left channel. The sample is the 24 bits that follow the first bit clock after the transition, MSB first. At least 25 bit clocks per half frame are needed.
- R4: With `fmt_i` = 4, 1 or 0, the sample is the last 24, 20 or 16 bits before the frame-clock transition that ends the half frame. Any earlier bits in that half are ignored. Frame clock high carries the left channel.
- R5: 16-bit and 20-bit words are sign-extended to 24 bits. Codes 0x7FFF and 0x7FFFF give 0x007FFF and 0x07FFFF, while 0x8000 and 0x80000 give 0xFF8000 and 0xF80000. The 24-bit full-scale code 0x7FFFFF passes through unchanged.
- R6: `valid_o` is a one-cycle pulse, raised after the right sample of a frame is latched, with `left_o` and `right_o` updated in that same cycle. Between pulses the outputs hold their values.
- R7: Any count of bit clocks per half frame from the word length up to 48 is accepted. This includes 16 bit clocks per half frame for the 16-bit right-justified mode.
- R8: Codes 5, 6 and 7 behave like code 2.
- R9: One pulse is produced per transmitted frame. A half frame that was not complete after reset produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, data taken on its rising edge |
| fclk_i | input | 1 | Frame clock selecting the channel |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 3 | Format select: 0 RJ16, 1 RJ20, 2 LJ24, 3 I2S, 4 RJ24, 5-7 LJ24 |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe, new frame on outputs |

## Verification
The hardest cases to reach are those where the half frame carries more bit clocks than the word. In those cases the right-justified modes must discard leading bits, and the left-justified and I2S modes must discard trailing bits. The stimulus therefore draws a random bit-clock count per frame, between the word length and 48, and fills every unused slot with random junk bits. A wrong window in either direction then corrupts the sample.

Each format group starts from reset with idle bits. It ends with a short trailing half frame, which is needed to flush the last right-justified right sample. This exercises the rule that a partial first half produces no sample. Frames with extreme codes are placed at the start of each group to drive the sign-extension boundaries.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W = 24;

  localparam logic [2:0] FMT_RJ16 = 3'd0;
  localparam logic [2:0] FMT_RJ20 = 3'd1;
  localparam logic [2:0] FMT_LJ24 = 3'd2;
  localparam logic [2:0] FMT_I2S  = 3'd3;
  localparam logic [2:0] FMT_RJ24 = 3'd4;

  typedef struct packed {
    logic       right_just;
    logic       delayed;
    logic [4:0] len;
  } fmt_info_t;

  function automatic fmt_info_t decode_fmt(input logic [2:0] code);
    fmt_info_t f;
    f.right_just = 1'b0;
    f.delayed    = 1'b0;
    f.len        = 5'd24;
    case (code)
      FMT_RJ16: begin f.right_just = 1'b1; f.len = 5'd16; end
      FMT_RJ20: begin f.right_just = 1'b1; f.len = 5'd20; end
      FMT_RJ24: begin f.right_just = 1'b1; f.len = 5'd24; end
      FMT_I2S:  f.delayed = 1'b1;
      default:  ;
    endcase
    return f;
  endfunction

  function automatic logic [SAMPLE_W-1:0] sext_word(input logic [SAMPLE_W-1:0] raw,
                                                    input logic [4:0] len);
    logic [SAMPLE_W-1:0] r;
    case (len)
      5'd16:   r = {{(SAMPLE_W-16){raw[15]}}, raw[15:0]};
      5'd20:   r = {{(SAMPLE_W-20){raw[19]}}, raw[19:0]};
      default: r = raw;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         rise_o
);
  logic [W-1:0] chain [STAGES];
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1][0];
  end

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1][0] & ~prev_q;
endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
  import pcm_rx_pkg::*;
#(
  parameter int SHW  = 32,
  parameter int CNTW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_rise,
  input  logic                ws_s,
  input  logic                sd_s,
  input  logic [2:0]          fmt,
  output logic                word_stb,
  output logic                word_left,
  output logic [SAMPLE_W-1:0] word_data
);
  localparam logic [CNTW-1:0] CMAX = '1;

  logic [SHW-1:0]  shreg;
  logic [SHW-1:0]  sh_next;
  logic [CNTW-1:0] cnt, cnt_next, lj_target;
  logic            ws_prev, started, seen_edge;
  logic            ws_edge, lj_hit, rj_hit;
  fmt_info_t       fi;

  always_comb begin
    fi        = decode_fmt(fmt);
    ws_edge   = started && (ws_s != ws_prev);
    sh_next   = {shreg[SHW-2:0], sd_s};
    if (ws_edge)          cnt_next = CNTW'(1);
    else if (cnt == CMAX) cnt_next = cnt;
    else                  cnt_next = cnt + CNTW'(1);
    lj_target = fi.delayed ? CNTW'(SAMPLE_W + 1) : CNTW'(SAMPLE_W);
    lj_hit    = started && !fi.right_just && (cnt_next == lj_target);
    rj_hit    = fi.right_just && ws_edge && seen_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= CMAX;
      ws_prev   <= 1'b0;
      started   <= 1'b0;
      seen_edge <= 1'b0;
      word_stb  <= 1'b0;
      word_left <= 1'b0;
      word_data <= '0;
    end else begin
      word_stb <= 1'b0;
      if (bit_rise) begin
        shreg   <= sh_next;
        ws_prev <= ws_s;
        started <= 1'b1;
        if (started) begin
          cnt <= cnt_next;
          if (ws_edge) seen_edge <= 1'b1;
        end
        if (rj_hit) begin
          word_stb  <= 1'b1;
          word_left <= ws_prev;
          word_data <= sext_word(shreg[SAMPLE_W-1:0], fi.len);
        end else if (lj_hit) begin
          word_stb  <= 1'b1;
          word_left <= fi.delayed ? ~ws_s : ws_s;
          word_data <= sh_next[SAMPLE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pcm_pair_out.sv
module pcm_pair_out
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                word_stb,
  input  logic                word_left,
  input  logic [SAMPLE_W-1:0] word_data,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] left_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_stb) begin
        if (word_left) begin
          left_hold <= word_data;
        end else begin
          left_o  <= left_hold;
          right_o <= word_data;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHIFT_W     = 32,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_i,
  input  logic                fclk_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int LINES = 3;

  logic [LINES-1:0]    lines_s;
  logic                bit_rise;
  logic                w_stb, w_left;
  logic [SAMPLE_W-1:0] w_data;

  pcm_edge_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({sdata_i, fclk_i, bclk_i}),
    .q_o(lines_s), .rise_o(bit_rise)
  );

  pcm_framer #(.SHW(SHIFT_W), .CNTW(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .bit_rise(bit_rise),
    .ws_s(lines_s[1]), .sd_s(lines_s[2]), .fmt(fmt_i),
    .word_stb(w_stb), .word_left(w_left), .word_data(w_data)
  );

  pcm_pair_out u_out (
    .clk(clk), .rst(rst),
    .word_stb(w_stb), .word_left(w_left), .word_data(w_data),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  fmt_i,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        valid_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !valid_o);

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R6
  right_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (right_o != $past(right_o)) |-> valid_o);

  // R6
  left_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (left_o != $past(left_o)) |-> valid_o);

  // R5
  sext16_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(fmt_i, 2) == 3'd0) |->
      (right_o[23:15] == 9'h000 || right_o[23:15] == 9'h1FF));

  // R5
  sext20_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(fmt_i, 2) == 3'd1) |->
      (right_o[23:19] == 5'h00 || right_o[23:19] == 5'h1F));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (.*);

// File: tb/pcm_serial_rx_test.sv
`timescale 1ns/1ps
module pcm_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
  logic [2:0]  fmt = 3'd2;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int errors = 0, checks = 0;
  int wr = 0, rd = 0;
  bit done = 0;
  logic [23:0] exp_l [0:255];
  logic [23:0] exp_r [0:255];

  always #2.5 clk = ~clk;

  pcm_serial_rx uut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int wlen(input logic [2:0] f);
    return (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : 24;
  endfunction
  function automatic bit is_rj(input logic [2:0] f);
    return f == 3'd0 || f == 3'd1 || f == 3'd4;
  endfunction
  function automatic logic [23:0] sext(input logic [2:0] f, input logic [23:0] raw);
    logic signed [31:0] t;
    int n = wlen(f);
    t = $signed({8'h00, raw} << (32 - n));
    t = t >>> (32 - n);
    return t[23:0];
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic v);
    sdata = v;
    wclk(4);
    bclk = 1'b1;
    wclk(4);
    bclk = 1'b0;
  endtask

  task automatic send_half(input logic [2:0] f, input logic lvl, input logic [23:0] w, input int bph);
    int n = wlen(f);
    fclk = lvl;
    for (int b = 0; b < bph; b++) begin
      logic v;
      v = logic'($urandom & 1);
      if (is_rj(f)) begin
        if (b >= bph - n) v = w[bph - 1 - b];
      end else if (f == 3'd3) begin
        if (b >= 1 && b <= 24) v = w[24 - b];
      end else begin
        if (b < 24) v = w[23 - b];
      end
      bit_out(v);
    end
  endtask

  task automatic reset_seq(input logic [2:0] f);
    fmt  = f;
    fclk = (f == 3'd3) ? 1'b1 : 1'b0;
    bclk = 1'b0;
    rst  = 1'b1;
    wclk(10);
    chk(left_o == 24'h0, "R1 left at reset", left_o, 24'h0);
    chk(right_o == 24'h0, "R1 right at reset", right_o, 24'h0);
    chk(valid_o == 1'b0, "R1 valid at reset", {23'h0, valid_o}, 24'h0);
    rst = 1'b0;
    wclk(1);
    chk(valid_o == 1'b0 && right_o == 24'h0, "R1 first cycle after reset", right_o, 24'h0);
    bit_out(1'b1);
    bit_out(1'b0);
  endtask

  task automatic run_group(input logic [2:0] f, input int nfr, input string tag);
    int n = wlen(f);
    int minb = is_rj(f) ? n : (f == 3'd3) ? 25 : 24;
    logic lvl = (f == 3'd3) ? 1'b0 : 1'b1;
    logic [23:0] mask = 24'hFFFFFF >> (24 - n);
    logic [23:0] maxp = mask >> 1;
    int wr0;
    reset_seq(f);
    wr0 = wr;
    for (int i = 0; i < nfr; i++) begin
      logic [23:0] l, r;
      int bph, sel;
      l = $urandom & mask;
      r = $urandom & mask;
      if (i == 0) begin l = maxp; r = maxp + 24'd1; end
      if (i == 1) begin l = maxp + 24'd1; r = maxp; end
      sel = $urandom % 3;
      bph = (i < 2 || sel == 0) ? minb : (sel == 1) ? 48 : minb + ($urandom % (49 - minb));
      exp_l[wr] = sext(f, l);
      exp_r[wr] = sext(f, r);
      wr++;
      send_half(f, lvl, l, bph);
      send_half(f, ~lvl, r, bph);
    end
    send_half(f, lvl, 24'h0, 4);
    wclk(40);
    chk(rd == wr, {tag, " R9 one pulse per frame"}, 24'(rd - wr0), 24'(wr - wr0));
  endtask

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (rd < wr) begin
        chk(left_o == exp_l[rd], $sformatf("R6 left frame %0d fmt %0d", rd, fmt), left_o, exp_l[rd]);
        chk(right_o == exp_r[rd], $sformatf("R6 right frame %0d fmt %0d", rd, fmt), right_o, exp_r[rd]);
        rd++;
      end else begin
        chk(1'b0, "R9 unexpected pulse", right_o, 24'h0);
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    run_group(3'd2, 8, "R2 LJ24");
    run_group(3'd3, 8, "R3 I2S");
    run_group(3'd4, 8, "R4 RJ24");
    run_group(3'd1, 8, "R4 R5 RJ20");
    run_group(3'd0, 8, "R4 R5 R7 RJ16");
    run_group(3'd6, 6, "R8 code6");
    reset_seq(3'd0);
    for (int i = 0; i < 3; i++) begin
      exp_l[wr] = sext(3'd0, 24'h00_8000 >> i);
      exp_r[wr] = sext(3'd0, 24'h00_7FFF - 24'(i));
      wr++;
      send_half(3'd0, 1'b1, 24'h00_8000 >> i, 16);
      send_half(3'd0, 1'b0, 24'h00_7FFF - 24'(i), 16);
    end
    send_half(3'd0, 1'b1, 24'h0, 4);
    wclk(40);
    chk(rd == wr, "R7 RJ16 at 32 bit clocks per frame", 24'(rd), 24'(wr));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule